// File: doc/BRIEF.md
# Isochronous OUT Endpoint Receive Buffer

This block holds the received data of one isochronous OUT endpoint in two packet buffers that take turns. The USB side delivers a packet as a simple strobe sequence: a start strobe, zero or more byte beats, then an end strobe that carries the result of the CRC check. A packet that ends with a good CRC stays in its buffer until software has read it. A packet that ends with a bad CRC is thrown away. A packet that arrives while both buffers are occupied is dropped in full and flagged as an overflow.

Software sees a 32-bit status word. Two of its flags are sticky and cleared by writing 1. A byte-read port drains the stored packets in the order they arrived. The interrupt output is the status events masked by an enable input.

Top module: `iso_out_rxbuf`

## Requirements
- R1: After reset, `csr_rdata` reads 0 and `irq` is low.
- R2: Status word layout: bit 0 is data-ready (read-only; writes have no effect), bit 1 is packet-done, bit 2 is overrun. Bit 3 is reserved and, like bits 31:4, always reads 0.
- R3: A packet ending with `pkt_crc_ok`=1 is stored. Data-ready reads 1 from the cycle after the end strobe. `rd_data` shows the current byte, and each `rd_pop` moves to the next byte.
- R4: A short packet and a zero-length packet each count as complete packets. A zero-length packet shows `rd_data`=0 and is removed by a single `rd_pop`.
- R5: Data-ready stays 1 until every stored packet in both buffers has been fully read. It drops to 0 after the last byte of the last stored packet is popped.
- R6: Packet-done sets on every end strobe of a packet that was given a buffer, whether its CRC was good or bad. Writing 1 to bit 1 clears it. If a set and a clear fall in the same cycle, the set wins.
- R7: A packet ending with `pkt_crc_ok`=0 is discarded. Its buffer becomes free again, and data-ready does not set.
- R8: When a start strobe arrives while neither buffer is free, the whole packet is discarded and overrun sets. The stored packets are left unchanged. Writing 1 to bit 2 clears overrun.
- R9: Packets are read out in the order they were stored, with the two buffers used alternately.
- R10: `irq` = `irq_en` AND (packet-done OR overrun). `irq_en` does not change any status bit.
- R11: Bytes beyond `DEPTH` in one packet are dropped. The stored packet then holds exactly `DEPTH` bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | Start-of-packet strobe |
| pkt_valid | input | 1 | Byte beat valid |
| pkt_data | input | 8 | Byte beat data |
| pkt_end | input | 1 | End-of-packet strobe |
| pkt_crc_ok | input | 1 | CRC result, sampled with `pkt_end` |
| csr_wr | input | 1 | Status-word write strobe |
| csr_wdata | input | 32 | Write data; 1 bits clear sticky flags |
| csr_rdata | output | 32 | Status word |
| rd_pop | input | 1 | Consume the current byte |
| rd_data | output | 8 | Current byte of the oldest stored packet |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `DEPTH`=16 instead of 256. At that size an over-length packet, in which only the first 16 bytes are kept, takes only a few dozen cycles. Filling both buffers and then overrunning them is just as short. Every byte can therefore be checked against its expected value while both buffers are occupied and a third packet arrives.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;

    localparam int BYTE_W   = 8;
    localparam int NUM_BUFS = 2;
    localparam int PTR_W    = 1;
    localparam int CSR_W    = 32;

    localparam int BIT_RDY  = 0;
    localparam int BIT_DONE = 1;
    localparam int BIT_OVR  = 2;

    typedef enum logic [1:0] {
        BUF_FREE = 2'd0,
        BUF_FILL = 2'd1,
        BUF_FULL = 2'd2
    } buf_state_e;

    typedef struct packed {
        logic              start;
        logic              valid;
        logic [BYTE_W-1:0] data;
        logic              last;
        logic              crc_ok;
    } sink_beat_t;

    typedef struct packed {
        logic ovr;
        logic done;
        logic rdy;
    } ep_status_t;

    function automatic logic [CSR_W-1:0] pack_status(ep_status_t s);
        logic [CSR_W-1:0] w;
        w           = '0;
        w[BIT_RDY]  = s.rdy;
        w[BIT_DONE] = s.done;
        w[BIT_OVR]  = s.ovr;
        return w;
    endfunction

endpackage

// File: rtl/iso_pkt_buf.sv
module iso_pkt_buf
    import iso_rx_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              claim,
    input  logic                              wr_en,
    input  logic [BYTE_W-1:0]                 wr_data,
    input  logic                              commit,
    input  logic                              abort,
    input  logic                              pop,
    output buf_state_e                        state,
    output logic [$clog2(DEPTH+1)-1:0]        len,
    output logic [BYTE_W-1:0]                 rd_data,
    output logic                              drain_last
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int LEN_W = $clog2(DEPTH+1);
    localparam logic [LEN_W-1:0] CAP = LEN_W'(DEPTH);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [LEN_W-1:0]  wr_cnt;
    logic [IDX_W-1:0]  rd_idx;
    logic              room;

    assign room = (wr_cnt < CAP);
    assign len  = wr_cnt;

    always_ff @(posedge clk) begin
        if (state == BUF_FILL && wr_en && room)
            mem[wr_cnt[IDX_W-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= BUF_FREE;
            wr_cnt <= '0;
            rd_idx <= '0;
        end else begin
            unique case (state)
                BUF_FREE: begin
                    if (claim) begin
                        state  <= BUF_FILL;
                        wr_cnt <= '0;
                        rd_idx <= '0;
                    end
                end
                BUF_FILL: begin
                    if (wr_en && room)
                        wr_cnt <= wr_cnt + 1'b1;
                    if (commit)
                        state <= BUF_FULL;
                    else if (abort)
                        state <= BUF_FREE;
                end
                BUF_FULL: begin
                    if (pop) begin
                        if (drain_last)
                            state <= BUF_FREE;
                        else
                            rd_idx <= rd_idx + 1'b1;
                    end
                end
                default: state <= BUF_FREE;
            endcase
        end
    end

    assign drain_last = (wr_cnt == '0) || (LEN_W'(rd_idx) == wr_cnt - 1'b1);
    assign rd_data    = (wr_cnt == '0) ? '0 : mem[rd_idx];

    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == BUF_FULL && !pop) |=> (state == BUF_FULL));

endmodule

// File: rtl/iso_rx_ctrl.sv
module iso_rx_ctrl
    import iso_rx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  sink_beat_t            beat,
    input  logic                  rd_pop,
    input  buf_state_e            st        [NUM_BUFS],
    input  logic [NUM_BUFS-1:0]   last_byte,
    output logic [NUM_BUFS-1:0]   claim,
    output logic [NUM_BUFS-1:0]   wr_en,
    output logic [NUM_BUFS-1:0]   commit,
    output logic [NUM_BUFS-1:0]   abort,
    output logic [NUM_BUFS-1:0]   pop,
    output logic [PTR_W-1:0]      drain_sel,
    output logic                  done_set,
    output logic                  ovr_set
);
    logic [PTR_W-1:0] fill_sel;
    logic             active;
    logic             target_free;
    logic             head_full;

    assign target_free = (st[fill_sel] == BUF_FREE);
    assign head_full   = (st[drain_sel] == BUF_FULL);

    for (genvar i = 0; i < NUM_BUFS; i++) begin : g_sel
        assign claim[i]  = beat.start && target_free && (fill_sel == PTR_W'(i));
        assign wr_en[i]  = beat.valid && active && (fill_sel == PTR_W'(i));
        assign commit[i] = beat.last && active && beat.crc_ok && (fill_sel == PTR_W'(i));
        assign abort[i]  = beat.last && active && !beat.crc_ok && (fill_sel == PTR_W'(i));
        assign pop[i]    = rd_pop && (st[i] == BUF_FULL) && (drain_sel == PTR_W'(i));
    end

    assign ovr_set  = beat.start && !target_free;
    assign done_set = beat.last && active;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_sel  <= '0;
            drain_sel <= '0;
            active    <= 1'b0;
        end else begin
            if (beat.start)
                active <= target_free;
            else if (beat.last) begin
                active <= 1'b0;
                if (active && beat.crc_ok)
                    fill_sel <= fill_sel + 1'b1;
            end
            if (rd_pop && head_full && last_byte[drain_sel])
                drain_sel <= drain_sel + 1'b1;
        end
    end

    // R9
    order_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (st[0] == BUF_FULL && st[1] == BUF_FULL) |-> (fill_sel == drain_sel));

    // R8
    no_claim_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (beat.start && st[0] != BUF_FREE && st[1] != BUF_FREE) |-> (claim == '0));

endmodule

// File: rtl/iso_rx_csr.sv
module iso_rx_csr
    import iso_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done_set,
    input  logic              ovr_set,
    input  logic              any_full,
    input  logic              csr_wr,
    input  logic [CSR_W-1:0]  csr_wdata,
    input  logic              irq_en,
    output logic [CSR_W-1:0]  csr_rdata,
    output logic              irq
);
    ep_status_t stat;
    logic       done_q, ovr_q;
    logic       clr_done, clr_ovr;

    assign clr_done = csr_wr && csr_wdata[BIT_DONE];
    assign clr_ovr  = csr_wr && csr_wdata[BIT_OVR];

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            done_q <= done_set || (done_q && !clr_done);
            ovr_q  <= ovr_set  || (ovr_q  && !clr_ovr);
        end
    end

    always_comb begin
        stat.rdy  = any_full;
        stat.done = done_q;
        stat.ovr  = ovr_q;
    end

    assign csr_rdata = pack_status(stat);
    assign irq       = irq_en && (done_q || ovr_q);

    // R6
    done_w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && csr_wdata[BIT_DONE] && !done_set) |=> !csr_rdata[BIT_DONE]);

    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovr_set |=> csr_rdata[BIT_OVR]);

endmodule

// File: rtl/iso_out_rxbuf.sv
module iso_out_rxbuf
    import iso_rx_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pkt_start,
    input  logic         pkt_valid,
    input  logic [7:0]   pkt_data,
    input  logic         pkt_end,
    input  logic         pkt_crc_ok,
    input  logic         csr_wr,
    input  logic [31:0]  csr_wdata,
    output logic [31:0]  csr_rdata,
    input  logic         rd_pop,
    output logic [7:0]   rd_data,
    input  logic         irq_en,
    output logic         irq
);
    localparam int LEN_W = $clog2(DEPTH+1);

    sink_beat_t            beat;
    buf_state_e            st        [NUM_BUFS];
    logic [LEN_W-1:0]      blen      [NUM_BUFS];
    logic [BYTE_W-1:0]     bdata     [NUM_BUFS];
    logic [NUM_BUFS-1:0]   last_byte, claim, wr_en, commit, abort, pop, full_vec;
    logic [PTR_W-1:0]      drain_sel;
    logic                  done_set, ovr_set;

    always_comb begin
        beat.start  = pkt_start;
        beat.valid  = pkt_valid;
        beat.data   = pkt_data;
        beat.last   = pkt_end;
        beat.crc_ok = pkt_crc_ok;
    end

    for (genvar i = 0; i < NUM_BUFS; i++) begin : g_buf
        iso_pkt_buf #(.DEPTH(DEPTH)) u_buf (
            .clk        (clk),
            .rst        (rst),
            .claim      (claim[i]),
            .wr_en      (wr_en[i]),
            .wr_data    (beat.data),
            .commit     (commit[i]),
            .abort      (abort[i]),
            .pop        (pop[i]),
            .state      (st[i]),
            .len        (blen[i]),
            .rd_data    (bdata[i]),
            .drain_last (last_byte[i])
        );
        assign full_vec[i] = (st[i] == BUF_FULL);
    end

    iso_rx_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .beat      (beat),
        .rd_pop    (rd_pop),
        .st        (st),
        .last_byte (last_byte),
        .claim     (claim),
        .wr_en     (wr_en),
        .commit    (commit),
        .abort     (abort),
        .pop       (pop),
        .drain_sel (drain_sel),
        .done_set  (done_set),
        .ovr_set   (ovr_set)
    );

    iso_rx_csr u_csr (
        .clk       (clk),
        .rst       (rst),
        .done_set  (done_set),
        .ovr_set   (ovr_set),
        .any_full  (|full_vec),
        .csr_wr    (csr_wr),
        .csr_wdata (csr_wdata),
        .irq_en    (irq_en),
        .csr_rdata (csr_rdata),
        .irq       (irq)
    );

    assign rd_data = bdata[drain_sel];

endmodule

// File: tb/iso_out_rxbuf_tb.sv
module iso_out_rxbuf_tb;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        pkt_start = 0, pkt_valid = 0, pkt_end = 0, pkt_crc_ok = 0;
    logic [7:0]  pkt_data = 0;
    logic        csr_wr = 0;
    logic [31:0] csr_wdata = 0;
    logic [31:0] csr_rdata;
    logic        rd_pop = 0;
    logic [7:0]  rd_data;
    logic        irq_en = 0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    iso_out_rxbuf #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst),
        .pkt_start(pkt_start), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .pkt_end(pkt_end), .pkt_crc_ok(pkt_crc_ok),
        .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .rd_pop(rd_pop), .rd_data(rd_data),
        .irq_en(irq_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_pkt(input int n, input logic [7:0] base, input logic crc,
                            input logic clr_at_end);
        @(negedge clk);
        pkt_start = 1;
        @(negedge clk);
        pkt_start = 0;
        for (int i = 0; i < n; i++) begin
            pkt_valid = 1;
            pkt_data  = base + 8'(i);
            @(negedge clk);
        end
        pkt_valid  = 0;
        pkt_end    = 1;
        pkt_crc_ok = crc;
        if (clr_at_end) begin
            csr_wr    = 1;
            csr_wdata = 32'h2;
        end
        @(negedge clk);
        pkt_end = 0;
        csr_wr  = 0;
    endtask

    task automatic csr_write(input logic [31:0] v);
        csr_wr    = 1;
        csr_wdata = v;
        @(negedge clk);
        csr_wr = 0;
    endtask

    task automatic drain(input string req, input int n, input logic [7:0] base);
        if (n == 0) begin
            chk(req, 32'(rd_data), 32'h0);
            rd_pop = 1;
            @(negedge clk);
            rd_pop = 0;
        end else begin
            for (int i = 0; i < n; i++) begin
                chk(req, 32'(rd_data), 32'(base + 8'(i)));
                rd_pop = 1;
                @(negedge clk);
            end
            rd_pop = 0;
        end
    endtask

    task automatic t_reset();
        chk("R1 status", csr_rdata, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
    endtask

    task automatic t_single();
        irq_en = 1;
        send_pkt(5, 8'h01, 1'b1, 1'b0);
        chk("R3 R6 rdy+done", csr_rdata, 32'h3);
        chk("R10 irq on", 32'(irq), 32'h1);
        csr_write(32'hFFFF_FFFB);   // R2: bit 0 and reserved bits are not writable
        chk("R2 R6 clear keeps rdy", csr_rdata, 32'h1);
        chk("R10 irq off", 32'(irq), 32'h0);
        drain("R3 data", 5, 8'h01);
        chk("R5 rdy clear", csr_rdata, 32'h0);
    endtask

    task automatic t_order();
        send_pkt(3, 8'h10, 1'b1, 1'b0);
        send_pkt(4, 8'h40, 1'b1, 1'b0);
        drain("R9 first", 3, 8'h10);
        chk("R5 rdy held", 32'(csr_rdata[0]), 32'h1);
        drain("R9 second", 4, 8'h40);
        chk("R5 rdy clear", 32'(csr_rdata[0]), 32'h0);
        csr_write(32'h6);
    endtask

    task automatic t_short_zero();
        send_pkt(0, 8'h00, 1'b1, 1'b0);
        chk("R4 zero rdy", 32'(csr_rdata[0]), 32'h1);
        send_pkt(1, 8'hA5, 1'b1, 1'b0);
        drain("R4 zero", 0, 8'h00);
        chk("R4 rdy after zero", 32'(csr_rdata[0]), 32'h1);
        drain("R4 short", 1, 8'hA5);
        chk("R4 rdy clear", 32'(csr_rdata[0]), 32'h0);
        csr_write(32'h6);
    endtask

    task automatic t_crc_bad();
        send_pkt(3, 8'h33, 1'b0, 1'b0);
        chk("R7 R6 bad crc", csr_rdata, 32'h2);
        csr_write(32'h2);
        send_pkt(2, 8'h50, 1'b1, 1'b0);
        chk("R7 reuse", csr_rdata, 32'h3);
        drain("R7 data", 2, 8'h50);
        csr_write(32'h6);
    endtask

    task automatic t_overflow();
        irq_en = 0;
        send_pkt(4, 8'h20, 1'b1, 1'b0);
        send_pkt(2, 8'h60, 1'b1, 1'b0);
        csr_write(32'h2);
        send_pkt(5, 8'h90, 1'b1, 1'b0);
        chk("R8 R6 ovr only", csr_rdata, 32'h5);
        chk("R10 masked", 32'(irq), 32'h0);
        irq_en = 1;
        #1;
        chk("R10 unmasked", 32'(irq), 32'h1);
        drain("R8 first intact", 4, 8'h20);
        drain("R8 second intact", 2, 8'h60);
        chk("R8 rdy clear", csr_rdata, 32'h4);
        csr_write(32'h4);
        chk("R8 clear", csr_rdata, 32'h0);
    endtask

    task automatic t_long();
        send_pkt(DEPTH + 3, 8'h80, 1'b1, 1'b0);
        drain("R11 bytes", DEPTH, 8'h80);
        chk("R11 length", 32'(csr_rdata[0]), 32'h0);
        csr_write(32'h6);
    endtask

    task automatic t_set_wins();
        send_pkt(1, 8'h77, 1'b1, 1'b1);
        chk("R6 set wins", 32'(csr_rdata[1]), 32'h1);
        drain("R6 data", 1, 8'h77);
        csr_write(32'h6);
    endtask

    initial begin
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_single();
        t_order();
        t_short_zero();
        t_crc_bad();
        t_overflow();
        t_long();
        t_set_wins();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule